// File: doc/BRIEF.md
# Leveled Interrupt Dispatch Controller

This block decides, on a cycle where the core asks for it, whether the highest pending interrupt level may be taken, and works out every register update the interrupt entry sequence needs. It looks at the pending level, the interrupt-level field of the status word, the pending and enable bit vectors and a per-level routing mask. From these it produces write strobes and write data for the saved-PC registers, the saved-status registers, a double-exception PC register, the status word and the exception cause register. It also produces a redirect address and a one-cycle taken strobe. All outputs are registered, so every update the core must commit appears together in the cycle after the request.

Levels above 1 are handled as true vectored interrupts. The PC and status are saved into that level's own registers, the status interrupt level is raised to the new level, and the fetch is redirected to that level's vector. Level 1 is not vectored on its own. It turns into an exception with a fixed cause code. The exception is a double exception if the core is already in exception mode. Otherwise it is a user-mode or kernel-mode exception, chosen by the user bit of the status word.

Vector addresses are fixed offsets from a base. With relocation enabled, the base is the vector base register, since each default vector minus the default base plus the register reduces to register plus offset. With relocation disabled, the base is a fixed default base.

Top module: `idc_dispatch`

## Requirements
- R1: A request (eval_i high) is accepted only when pend_level_i is strictly greater than status_i[3:0] and is no greater than NUM_LEVELS; levels 0 and NUM_LEVELS+1..15 are always rejected.
- R2: A request is also rejected unless the routing mask of the requested level (level_masks_i slice level-1) ANDed with pending_i and enable_i has at least one bit set.
- R3: For an accepted level L above 1, epc_we_o and eps_we_o both have only bit L-1 set, saved_pc_o carries pc_i and saved_status_o carries the old status_i.
- R4: For an accepted level L above 1, status_wdata_o equals status_i with bits [3:0] replaced by L and the exception-mode bit (bit 4) set, and status_we_o is high.
- R5: For an accepted level L above 1, kind_o is 0 and target_o is the base plus 0x180 + (L-2)*0x40.
- R6: For an accepted level 1, cause_we_o is high and cause_wdata_o is 4; for levels above 1, cause_we_o stays low.
- R7: For an accepted level 1 with status bit 4 set, kind_o is 3 (double), target_o is base plus 0x3C0, and pc_i is saved through depc_we_o when HAS_DEPC is 1, otherwise through epc_we_o bit 0.
- R8: For an accepted level 1 with status bit 4 clear, epc_we_o has only bit 0 set, and the user bit (status bit 5) selects kind_o 2 with target base plus 0x340 or, when clear, kind_o 1 with target base plus 0x300.
- R9: For an accepted level 1, status_wdata_o equals status_i with bit 4 set and all other bits kept.
- R10: With RELOCATE set, the base used for every target is vecbase_i; with RELOCATE clear it is DEF_VECBASE.
- R11: take_o and all update outputs appear in the cycle after the clock edge that samples eval_i, last exactly one cycle per request, and take_o is low after any edge where eval_i was low.
- R12: When a request is rejected or absent, take_o and every write strobe are low and the write data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Evaluate the pending request this cycle |
| pend_level_i | input | 4 | Highest pending interrupt level |
| pending_i | input | NUM_IRQ | Pending interrupt bits |
| enable_i | input | NUM_IRQ | Interrupt enable bits |
| level_masks_i | input | NUM_LEVELS*NUM_IRQ | Per-level routing masks, level L at slice L-1 |
| pc_i | input | XLEN | Current program counter |
| status_i | input | XLEN | Current status word |
| vecbase_i | input | XLEN | Vector base register |
| take_o | output | 1 | Interrupt entry taken strobe |
| kind_o | output | 2 | Entry kind: 0 level, 1 kernel, 2 user, 3 double |
| target_o | output | XLEN | Redirect address |
| epc_we_o | output | NUM_LEVELS | Saved-PC write strobes, bit L-1 for level L |
| eps_we_o | output | NUM_LEVELS | Saved-status write strobes, bit L-1 for level L |
| depc_we_o | output | 1 | Double-exception PC write strobe |
| saved_pc_o | output | XLEN | Data for the saved-PC writes |
| saved_status_o | output | XLEN | Data for the saved-status write |
| status_we_o | output | 1 | Status word write strobe |
| status_wdata_o | output | XLEN | New status word |
| cause_we_o | output | 1 | Cause register write strobe |
| cause_wdata_o | output | CAUSE_W | New cause value |

## Verification
Every result of this block is due exactly one clock after the rising edge that samples eval_i: the acceptance decision, the write strobes, the data words and the redirect target all come from one register stage. The bench changes inputs on the falling edge. It samples all outputs at the next falling edge, half a cycle after the registering edge, and compares them with values computed from the inputs it drove. It then drops eval_i and samples once more a cycle later to confirm that the strobe and the write enables have returned low.

// File: rtl/idc_pkg.sv
package idc_pkg;

    // Status word layout
    localparam int LVL_W   = 4;   // interrupt-level field is status[LVL_W-1:0]
    localparam int ST_EXCM = 4;   // exception-mode bit
    localparam int ST_USER = 5;   // user-mode bit

    // Cause code written for a level-1 entry
    localparam int LVL1_CAUSE = 4;

    // Vector offsets from the vector base
    localparam logic [31:0] OFF_KERNEL = 32'h0000_0300;
    localparam logic [31:0] OFF_USER   = 32'h0000_0340;
    localparam logic [31:0] OFF_DOUBLE = 32'h0000_03C0;
    localparam logic [31:0] OFF_LEVEL0 = 32'h0000_0180;   // level 2
    localparam logic [31:0] OFF_STEP   = 32'h0000_0040;   // per level above 2

    typedef enum logic [1:0] {
        K_LEVEL  = 2'd0,
        K_KERNEL = 2'd1,
        K_USER   = 2'd2,
        K_DOUBLE = 2'd3
    } entry_kind_e;

    function automatic logic [31:0] level_offset(int unsigned lvl);
        return OFF_LEVEL0 + (32'(lvl) - 32'd2) * OFF_STEP;
    endfunction

endpackage

// File: rtl/idc_accept.sv
module idc_accept
    import idc_pkg::*;
#(
    parameter int NUM_LEVELS = 6,
    parameter int NUM_IRQ    = 32
) (
    input  logic [LVL_W-1:0]              level_i,
    input  logic [LVL_W-1:0]              cur_level_i,
    input  logic [NUM_IRQ-1:0]            pending_i,
    input  logic [NUM_IRQ-1:0]            enable_i,
    input  logic [NUM_LEVELS*NUM_IRQ-1:0] masks_i,
    output logic                          accept_o
);

    localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LEVELS);

    logic [NUM_LEVELS:0] hit;
    logic                in_range;
    logic                sel_hit;

    assign hit[0] = 1'b0;

    // One live-source detector per level
    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
        assign hit[l] = |(masks_i[(l-1)*NUM_IRQ +: NUM_IRQ] & pending_i & enable_i);
    end

    always_comb begin
        in_range = (level_i > cur_level_i) && (level_i <= MAX_LVL);
        sel_hit  = 1'b0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (level_i == LVL_W'(l)) begin
                sel_hit = hit[l];
            end
        end
        accept_o = in_range && sel_hit;
    end

endmodule

// File: rtl/idc_vector.sv
module idc_vector
    import idc_pkg::*;
#(
    parameter int               NUM_LEVELS  = 6,
    parameter int               XLEN        = 32,
    parameter bit               RELOCATE    = 1'b1,
    parameter logic [XLEN-1:0]  DEF_VECBASE = XLEN'(32'hD000_0000)
) (
    input  logic [XLEN-1:0]            vecbase_i,
    output logic [XLEN-1:0]            kernel_vec_o,
    output logic [XLEN-1:0]            user_vec_o,
    output logic [XLEN-1:0]            double_vec_o,
    output logic [NUM_LEVELS*XLEN-1:0] level_vec_o
);

    logic [XLEN-1:0] base;

    // Default vector minus default base plus register collapses to register + offset
    if (RELOCATE) begin : g_reloc
        assign base = vecbase_i;
    end else begin : g_fixed
        logic [XLEN-1:0] unused_vb;
        assign unused_vb = vecbase_i;
        assign base      = DEF_VECBASE;
    end

    assign kernel_vec_o = base + XLEN'(OFF_KERNEL);
    assign user_vec_o   = base + XLEN'(OFF_USER);
    assign double_vec_o = base + XLEN'(OFF_DOUBLE);

    // Slot 0 (level 1) is never used as a direct vector
    assign level_vec_o[XLEN-1:0] = '0;
    for (genvar l = 2; l <= NUM_LEVELS; l++) begin : g_lvec
        assign level_vec_o[(l-1)*XLEN +: XLEN] = base + XLEN'(level_offset(l));
    end

endmodule

// File: rtl/idc_entry.sv
module idc_entry
    import idc_pkg::*;
#(
    parameter int NUM_LEVELS = 6,
    parameter int XLEN       = 32,
    parameter bit HAS_DEPC   = 1'b1
) (
    input  logic                       accept_i,
    input  logic [LVL_W-1:0]           level_i,
    input  logic [XLEN-1:0]            status_i,
    input  logic [XLEN-1:0]            kernel_vec_i,
    input  logic [XLEN-1:0]            user_vec_i,
    input  logic [XLEN-1:0]            double_vec_i,
    input  logic [NUM_LEVELS*XLEN-1:0] level_vec_i,
    output entry_kind_e                kind_o,
    output logic [XLEN-1:0]            target_o,
    output logic [NUM_LEVELS-1:0]      epc_we_o,
    output logic [NUM_LEVELS-1:0]      eps_we_o,
    output logic                       depc_we_o,
    output logic                       status_we_o,
    output logic [XLEN-1:0]            status_new_o,
    output logic                       cause_we_o
);

    always_comb begin
        kind_o       = K_LEVEL;
        target_o     = '0;
        epc_we_o     = '0;
        eps_we_o     = '0;
        depc_we_o    = 1'b0;
        status_we_o  = 1'b0;
        status_new_o = '0;
        cause_we_o   = 1'b0;

        if (accept_i) begin
            status_we_o  = 1'b1;
            status_new_o = status_i;
            if (level_i > LVL_W'(1)) begin
                // Vectored level: per-level save slots and vector
                for (int l = 2; l <= NUM_LEVELS; l++) begin
                    if (level_i == LVL_W'(l)) begin
                        epc_we_o[l-1] = 1'b1;
                        eps_we_o[l-1] = 1'b1;
                        target_o      = level_vec_i[(l-1)*XLEN +: XLEN];
                    end
                end
                status_new_o[LVL_W-1:0] = level_i;
                status_new_o[ST_EXCM]   = 1'b1;
                kind_o                  = K_LEVEL;
            end else begin
                // Level 1 becomes an exception with a fixed cause
                cause_we_o = 1'b1;
                if (status_i[ST_EXCM]) begin
                    kind_o   = K_DOUBLE;
                    target_o = double_vec_i;
                    if (HAS_DEPC) begin
                        depc_we_o = 1'b1;
                    end else begin
                        epc_we_o[0] = 1'b1;
                    end
                end else begin
                    epc_we_o[0] = 1'b1;
                    if (status_i[ST_USER]) begin
                        kind_o   = K_USER;
                        target_o = user_vec_i;
                    end else begin
                        kind_o   = K_KERNEL;
                        target_o = kernel_vec_i;
                    end
                end
                // Exception mode is raised only after the kind was chosen
                status_new_o[ST_EXCM] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/idc_dispatch.sv
module idc_dispatch
    import idc_pkg::*;
#(
    parameter int               NUM_LEVELS  = 6,
    parameter int               NUM_IRQ     = 32,
    parameter int               XLEN        = 32,
    parameter int               CAUSE_W     = 6,
    parameter bit               HAS_DEPC    = 1'b1,
    parameter bit               RELOCATE    = 1'b1,
    parameter logic [XLEN-1:0]  DEF_VECBASE = XLEN'(32'hD000_0000)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          eval_i,
    input  logic [3:0]                    pend_level_i,
    input  logic [NUM_IRQ-1:0]            pending_i,
    input  logic [NUM_IRQ-1:0]            enable_i,
    input  logic [NUM_LEVELS*NUM_IRQ-1:0] level_masks_i,
    input  logic [XLEN-1:0]               pc_i,
    input  logic [XLEN-1:0]               status_i,
    input  logic [XLEN-1:0]               vecbase_i,
    output logic                          take_o,
    output logic [1:0]                    kind_o,
    output logic [XLEN-1:0]               target_o,
    output logic [NUM_LEVELS-1:0]         epc_we_o,
    output logic [NUM_LEVELS-1:0]         eps_we_o,
    output logic                          depc_we_o,
    output logic [XLEN-1:0]               saved_pc_o,
    output logic [XLEN-1:0]               saved_status_o,
    output logic                          status_we_o,
    output logic [XLEN-1:0]               status_wdata_o,
    output logic                          cause_we_o,
    output logic [CAUSE_W-1:0]            cause_wdata_o
);

    typedef struct packed {
        logic                  take;
        entry_kind_e           kind;
        logic [XLEN-1:0]       target;
        logic [NUM_LEVELS-1:0] epc_we;
        logic [NUM_LEVELS-1:0] eps_we;
        logic                  depc_we;
        logic [XLEN-1:0]       saved_pc;
        logic [XLEN-1:0]       saved_status;
        logic                  status_we;
        logic [XLEN-1:0]       status_wdata;
        logic                  cause_we;
        logic [CAUSE_W-1:0]    cause_wdata;
    } upd_t;

    upd_t out_d, out_q;

    logic                       accept;
    logic [XLEN-1:0]            kvec, uvec, dvec;
    logic [NUM_LEVELS*XLEN-1:0] lvec;
    entry_kind_e                e_kind;
    logic [XLEN-1:0]            e_target;
    logic [NUM_LEVELS-1:0]      e_epc_we, e_eps_we;
    logic                       e_depc_we, e_st_we, e_cause_we;
    logic [XLEN-1:0]            e_st_new;

    idc_accept #(
        .NUM_LEVELS (NUM_LEVELS),
        .NUM_IRQ    (NUM_IRQ)
    ) i_accept (
        .level_i     (pend_level_i),
        .cur_level_i (status_i[LVL_W-1:0]),
        .pending_i   (pending_i),
        .enable_i    (enable_i),
        .masks_i     (level_masks_i),
        .accept_o    (accept)
    );

    idc_vector #(
        .NUM_LEVELS  (NUM_LEVELS),
        .XLEN        (XLEN),
        .RELOCATE    (RELOCATE),
        .DEF_VECBASE (DEF_VECBASE)
    ) i_vector (
        .vecbase_i    (vecbase_i),
        .kernel_vec_o (kvec),
        .user_vec_o   (uvec),
        .double_vec_o (dvec),
        .level_vec_o  (lvec)
    );

    idc_entry #(
        .NUM_LEVELS (NUM_LEVELS),
        .XLEN       (XLEN),
        .HAS_DEPC   (HAS_DEPC)
    ) i_entry (
        .accept_i     (eval_i && accept),
        .level_i      (pend_level_i),
        .status_i     (status_i),
        .kernel_vec_i (kvec),
        .user_vec_i   (uvec),
        .double_vec_i (dvec),
        .level_vec_i  (lvec),
        .kind_o       (e_kind),
        .target_o     (e_target),
        .epc_we_o     (e_epc_we),
        .eps_we_o     (e_eps_we),
        .depc_we_o    (e_depc_we),
        .status_we_o  (e_st_we),
        .status_new_o (e_st_new),
        .cause_we_o   (e_cause_we)
    );

    always_comb begin
        out_d = '0;
        if (eval_i && accept) begin
            out_d.take         = 1'b1;
            out_d.kind         = e_kind;
            out_d.target       = e_target;
            out_d.epc_we       = e_epc_we;
            out_d.eps_we       = e_eps_we;
            out_d.depc_we      = e_depc_we;
            out_d.saved_pc     = pc_i;
            out_d.saved_status = status_i;
            out_d.status_we    = e_st_we;
            out_d.status_wdata = e_st_new;
            out_d.cause_we     = e_cause_we;
            out_d.cause_wdata  = e_cause_we ? CAUSE_W'(LVL1_CAUSE) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign take_o         = out_q.take;
    assign kind_o         = out_q.kind;
    assign target_o       = out_q.target;
    assign epc_we_o       = out_q.epc_we;
    assign eps_we_o       = out_q.eps_we;
    assign depc_we_o      = out_q.depc_we;
    assign saved_pc_o     = out_q.saved_pc;
    assign saved_status_o = out_q.saved_status;
    assign status_we_o    = out_q.status_we;
    assign status_wdata_o = out_q.status_wdata;
    assign cause_we_o     = out_q.cause_we;
    assign cause_wdata_o  = out_q.cause_wdata;

endmodule

// File: rtl/idc_dispatch_chk.sv
module idc_dispatch_chk
    import idc_pkg::*;
#(
    parameter int NUM_LEVELS = 6,
    parameter int XLEN       = 32,
    parameter int CAUSE_W    = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  eval_i,
    input logic                  take_o,
    input logic [1:0]            kind_o,
    input logic [NUM_LEVELS-1:0] epc_we_o,
    input logic [NUM_LEVELS-1:0] eps_we_o,
    input logic                  depc_we_o,
    input logic                  status_we_o,
    input logic [XLEN-1:0]       status_wdata_o,
    input logic                  cause_we_o,
    input logic [CAUSE_W-1:0]    cause_wdata_o
);

    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (epc_we_o == '0 && eps_we_o == '0 && !depc_we_o
                     && !status_we_o && !cause_we_o));

    a_r11_one_pc_save: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (status_we_o && $countones({epc_we_o, depc_we_o}) == 1));

    a_r11_no_eval_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> !take_o);

    a_r3_paired_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && kind_o == 2'd0) |-> (eps_we_o == epc_we_o && !cause_we_o));

    a_r4_level_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && kind_o == 2'd0) |->
            (epc_we_o == (NUM_LEVELS'(1) << (status_wdata_o[LVL_W-1:0] - 4'd1))));

    a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && kind_o != 2'd0) |->
            (cause_we_o && cause_wdata_o == CAUSE_W'(LVL1_CAUSE) && eps_we_o == '0));

    a_r9_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> status_wdata_o[ST_EXCM]);

endmodule

bind idc_dispatch idc_dispatch_chk #(
    .NUM_LEVELS (NUM_LEVELS),
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W)
) i_idc_dispatch_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .eval_i         (eval_i),
    .take_o         (take_o),
    .kind_o         (kind_o),
    .epc_we_o       (epc_we_o),
    .eps_we_o       (eps_we_o),
    .depc_we_o      (depc_we_o),
    .status_we_o    (status_we_o),
    .status_wdata_o (status_wdata_o),
    .cause_we_o     (cause_we_o),
    .cause_wdata_o  (cause_wdata_o)
);

// File: tb/test_idc_dispatch.sv
module test_idc_dispatch;

    localparam int NL = 6;
    localparam int NI = 32;
    localparam int XL = 32;
    localparam int CW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           eval = 1'b0;
    logic [3:0]     lvl = '0;
    logic [NI-1:0]  pend = '0, en = '0;
    logic [NL*NI-1:0] masks = '0;
    logic [XL-1:0]  pc = '0, st = '0, vb = '0;

    logic           take;
    logic [1:0]     kind;
    logic [XL-1:0]  target, spc, sst, swd;
    logic [NL-1:0]  epc_we, eps_we;
    logic           depc_we, st_we, cause_we;
    logic [CW-1:0]  cause_wd;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    idc_dispatch i_idc_dispatch (
        .clk(clk), .rst_n(rst_n), .eval_i(eval), .pend_level_i(lvl),
        .pending_i(pend), .enable_i(en), .level_masks_i(masks),
        .pc_i(pc), .status_i(st), .vecbase_i(vb),
        .take_o(take), .kind_o(kind), .target_o(target),
        .epc_we_o(epc_we), .eps_we_o(eps_we), .depc_we_o(depc_we),
        .saved_pc_o(spc), .saved_status_o(sst),
        .status_we_o(st_we), .status_wdata_o(swd),
        .cause_we_o(cause_we), .cause_wdata_o(cause_wd)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected-value model built from the requirements
    function automatic bit exp_accept(logic [3:0] l, logic [XL-1:0] s,
                                      logic [NI-1:0] p, logic [NI-1:0] e,
                                      logic [NL*NI-1:0] m);
        bit h = 0;
        if (l <= s[3:0] || l > 4'(NL) || l == 0) return 0;
        for (int k = 1; k <= NL; k++)
            if (l == 4'(k)) h = |(m[(k-1)*NI +: NI] & p & e);
        return h;
    endfunction

    task automatic run_case(logic [3:0] l, logic [XL-1:0] s, logic [NI-1:0] p,
                            logic [NI-1:0] e, logic [XL-1:0] pcv, logic [XL-1:0] vbv);
        bit acc;
        logic [XL-1:0] exp_st;
        @(negedge clk);
        lvl = l; st = s; pend = p; en = e; pc = pcv; vb = vbv; eval = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc = exp_accept(l, s, p, e, masks);
        chk("R1", "take", 64'(take), 64'(acc));
        if (!acc) begin
            chk("R12", "strobes", 64'({epc_we, eps_we, depc_we, st_we, cause_we}), 64'd0);
            chk("R12", "data", 64'(swd | spc | sst | target), 64'd0);
        end else if (l > 4'd1) begin
            exp_st = s; exp_st[3:0] = l; exp_st[4] = 1'b1;
            chk("R3", "epc_we", 64'(epc_we), 64'(1) << (l - 1));
            chk("R3", "eps_we", 64'(eps_we), 64'(1) << (l - 1));
            chk("R3", "saved_pc", 64'(spc), 64'(pcv));
            chk("R3", "saved_status", 64'(sst), 64'(s));
            chk("R4", "status", 64'({st_we, swd}), 64'({1'b1, exp_st}));
            chk("R5", "kind", 64'(kind), 64'd0);
            chk("R10", "target", 64'(target),
                64'(vbv + 32'h180 + (32'(l) - 32'd2) * 32'h40));
            chk("R6", "cause_we", 64'(cause_we), 64'd0);
        end else begin
            exp_st = s; exp_st[4] = 1'b1;
            chk("R6", "cause", 64'({cause_we, cause_wd}), 64'({1'b1, 6'd4}));
            chk("R9", "status", 64'({st_we, swd}), 64'({1'b1, exp_st}));
            chk("R3", "eps_we", 64'(eps_we), 64'd0);
            if (s[4]) begin
                chk("R7", "kind", 64'(kind), 64'd3);
                chk("R7", "depc/epc", 64'({depc_we, epc_we}), 64'({1'b1, 6'd0}));
                chk("R7", "saved_pc", 64'(spc), 64'(pcv));
                chk("R10", "target", 64'(target), 64'(vbv + 32'h3C0));
            end else begin
                chk("R8", "kind", 64'(kind), s[5] ? 64'd2 : 64'd1);
                chk("R8", "depc/epc", 64'({depc_we, epc_we}), 64'({1'b0, 6'd1}));
                chk("R8", "saved_pc", 64'(spc), 64'(pcv));
                chk("R10", "target", 64'(target),
                    64'(vbv + (s[5] ? 32'h340 : 32'h300)));
            end
        end
        eval = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "take after idle", 64'({take, st_we, epc_we, depc_we}), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R12", "reset take", 64'(take), 64'd0);
        chk("R12", "reset strobes", 64'({epc_we, eps_we, depc_we, st_we, cause_we}), 64'd0);
        rst_n = 1'b1;
        masks = '1;

        // Directed corners
        run_case(4'd3, 32'h0000_0001, '1, '1, 32'h1000, 32'h4000_0000);   // high level
        run_case(4'd6, 32'h0000_0005, '1, '1, 32'h1004, 32'h4000_0000);   // top level
        run_case(4'd7, 32'h0000_0000, '1, '1, 32'h1008, 32'h4000_0000);   // above max (R1)
        run_case(4'd2, 32'h0000_0002, '1, '1, 32'h100C, 32'h4000_0000);   // equal to current (R1)
        run_case(4'd0, 32'h0000_0000, '1, '1, 32'h1010, 32'h4000_0000);   // level 0 (R1)
        run_case(4'd1, 32'h0000_0000, '1, '1, 32'h2000, 32'h5000_1000);   // kernel (R8)
        run_case(4'd1, 32'h0000_0020, '1, '1, 32'h2004, 32'h5000_1000);   // user (R8)
        run_case(4'd1, 32'h0000_0030, '1, '1, 32'h2008, 32'h5000_1000);   // double (R7)
        masks = '0;
        masks[2*NI +: NI] = 32'h0000_00F0;
        run_case(4'd3, 32'h0, 32'h0000_000F, '1, 32'h3000, 32'h0);        // mask miss (R2)
        run_case(4'd3, 32'h0, 32'h0000_0010, 32'h0000_0000, 32'h3004, 32'h0); // disabled (R2)
        run_case(4'd3, 32'h0, 32'h0000_0010, 32'h0000_0010, 32'h3008, 32'h0); // one live bit (R2)

        // Random mix
        for (int k = 0; k < NL; k++) masks[k*NI +: NI] = $urandom & $urandom;
        for (int t = 0; t < 400; t++) begin
            logic [3:0]    rl;
            logic [XL-1:0] rs;
            rl = ($urandom % 10 == 0) ? 4'(7 + $urandom % 9) : 4'($urandom % 7);
            rs = $urandom;
            rs[3:0] = 4'($urandom % 4);
            run_case(rl, rs, $urandom, $urandom, $urandom, {$urandom} & 32'hFFFF_F000);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule